// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames, presented as a byte stream with a valid strobe and a last-byte marker, and stores them in a circular region of a local packet memory. The memory is divided into 256-byte pages. The ring spans from a start page up to, but not including, a stop page. Every stored frame takes a whole number of pages and begins with a 4-byte link header. The header gives the receive status, the page where the following frame will begin, and the stored length. A host driver reads frames out of the ring and moves a boundary page forward to free space.

When the first byte of a frame arrives, the block compares the free space between the current page and the boundary with the size of a maximum frame, and it checks the stop command bit. If the frame is accepted, the data is written from offset 4 of the current page onward, and the write address wraps from the stop page back to the start page. Short frames are padded with zeros. The header is written last, once the length is known. The block then reports the next current page together with a one-cycle receive interrupt pulse. If the frame is refused, its bytes are taken in and discarded, and nothing is written.

The host owns the current-page register. It loads that register from `next_page` whenever `rx_irq` pulses. The ring inputs must stay steady while a frame is in flight. The default parameters give 16-bit byte addresses. A 32 KB memory that is decoded from 16-bit addresses covers the usual ring placement.

Top module: `rx_ring_writer`

## Requirements
- R1: When `stop_cmd` is high as the first byte of a frame arrives, the whole frame is discarded: no memory write and no `rx_irq`.
- R2: Free bytes are `bnd_pg*256 - cur_pg*256` when the current page is below the boundary page. Otherwise they are `(stop_pg - start_pg)*256 - (cur_pg - bnd_pg)*256`. A frame is accepted only when the free bytes are at least MAX_FRAME+4 (1518 by default).
- R3: A refused frame is consumed with `in_ready` high and has no effect: no memory write, and no `rx_irq` pulse.
- R4: Data byte i of an accepted frame goes to byte address `cur_pg*256 + 4 + i`. Bytes are written in arrival order, one per accepted input byte.
- R5: When the data write address reaches `stop_pg*256`, it continues at `start_pg*256`. Every write lies inside the ring.
- R6: A frame shorter than MIN_FRAME bytes (60 by default) is extended with zero bytes up to MIN_FRAME bytes. The stored length L is the padded length.
- R7: The header takes bytes 0 to 3 of the current page. In that order they hold 0x01 (received OK), the next page, the low byte of (L+4), and the high byte of (L+4).
- R8: The next page is `cur_pg + ceil((L+8)/256)`. If that value is at or beyond `stop_pg`, `(stop_pg - start_pg)` is subtracted from it.
- R9: After the last header write, `rx_irq` is high for exactly one cycle, and `next_page` carries the next page in that cycle.
- R10: While padding or writing the header, `in_ready` is low and a memory write takes place in every such cycle.
- R11: After reset, `in_ready` is high, and `mem_we` and `rx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pg | input | PG_W | First page of the ring |
| stop_pg | input | PG_W | Page just past the end of the ring |
| bnd_pg | input | PG_W | Boundary page held by the reader |
| cur_pg | input | PG_W | Page where the next frame is stored |
| stop_cmd | input | 1 | Receiver stopped; frames are refused |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block can take a byte this cycle |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PG_W+8 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| next_page | output | PG_W | New current page, valid while rx_irq is high |
| rx_irq | output | 1 | One-cycle pulse when a frame has been stored |

## Verification
The bench sets the current page one page below the stop page. In that case the next-page sum lands exactly on the stop page, and a design that compares with "greater than" instead of "at or beyond" would report a page outside the ring. It also places a long frame near the top of the ring. If the wrap were missing, data would be written past the stop page. If the wrap were taken one byte late or early, the bytes would shift by one. It offers rings with 5 and 6 free pages around the 1518-byte threshold, and it asserts the stop bit. A wrong space rule or a missing stop check would then show up as writes during a discarded frame. A one-byte frame and a 30-byte frame test the zero padding and the length field, which a design that counts only the received bytes would get wrong.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int PG_W      = 8,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] cur_pg,
  input  logic            stop_cmd,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            in_ready,
  output logic            mem_we,
  output logic [PG_W+7:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic [PG_W-1:0] next_page,
  output logic            rx_irq
);
  localparam int AW    = PG_W + 8;
  localparam int SW    = AW + 2;
  localparam int LEN_W = $clog2(MAX_FRAME + 1) + 1;
  localparam int NEED  = MAX_FRAME + 4;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_PAD, S_HDR, S_DROP} state_t;
  state_t st;

  logic [AW-1:0]    wp;
  logic [LEN_W-1:0] len;
  logic [1:0]       hidx;
  logic [PG_W-1:0]  base_l, start_l, stop_l;

  logic idle, discard;
  assign idle    = (st == S_IDLE);
  assign discard = (st == S_DROP);

  // free space check at frame start
  logic signed [SW-1:0] s_idx, s_bnd, s_sta, s_stp, avail;
  assign s_idx = $signed({2'b00, cur_pg,   8'h00});
  assign s_bnd = $signed({2'b00, bnd_pg,   8'h00});
  assign s_sta = $signed({2'b00, start_pg, 8'h00});
  assign s_stp = $signed({2'b00, stop_pg,  8'h00});
  assign avail = (s_idx < s_bnd) ? (s_bnd - s_idx) : ((s_stp - s_sta) - (s_idx - s_bnd));

  logic grant;
  assign grant = !stop_cmd && (avail >= $signed(SW'(NEED)));

  // data write address with wrap
  logic [PG_W-1:0] ring_start, ring_stop;
  logic [AW-1:0]   wa, wa_inc, wp_nx;
  assign ring_start = idle ? start_pg : start_l;
  assign ring_stop  = idle ? stop_pg  : stop_l;
  assign wa     = idle ? {cur_pg, 8'h04} : wp;
  assign wa_inc = wa + AW'(1);
  assign wp_nx  = (wa_inc == {ring_stop, 8'h00}) ? {ring_start, 8'h00} : wa_inc;

  // next page and header fields
  logic [LEN_W-1:0] total, len_p1;
  logic [LEN_W:0]   rnd;
  logic [PG_W:0]    np_sum, np_fix;
  logic [PG_W-1:0]  np;
  assign total  = len + LEN_W'(4);
  assign len_p1 = len + LEN_W'(1);
  assign rnd    = {1'b0, len} + (LEN_W+1)'(8 + 255);
  assign np_sum = {1'b0, base_l} + (PG_W+1)'(rnd >> 8);
  assign np_fix = np_sum - {1'b0, stop_l - start_l};
  assign np     = (np_sum >= {1'b0, stop_l}) ? np_fix[PG_W-1:0] : np_sum[PG_W-1:0];

  logic [7:0] hdr_byte;
  always_comb begin
    case (hidx)
      2'd0:    hdr_byte = 8'h01;
      2'd1:    hdr_byte = 8'(np);
      2'd2:    hdr_byte = total[7:0];
      default: hdr_byte = 8'(total >> 8);
    endcase
  end

  assign in_ready = (st == S_IDLE) || (st == S_DATA) || (st == S_DROP);

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = wa;
    mem_wdata = in_data;
    case (st)
      S_IDLE: mem_we = in_valid && grant;
      S_DATA: mem_we = in_valid;
      S_PAD: begin
        mem_we    = 1'b1;
        mem_wdata = 8'h00;
      end
      S_HDR: begin
        mem_we    = 1'b1;
        mem_addr  = {base_l, 6'b0, hidx};
        mem_wdata = hdr_byte;
      end
      default: mem_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wp        <= '0;
      len       <= '0;
      hidx      <= '0;
      base_l    <= '0;
      start_l   <= '0;
      stop_l    <= '0;
      next_page <= '0;
      rx_irq    <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          base_l  <= cur_pg;
          start_l <= start_pg;
          stop_l  <= stop_pg;
          len     <= LEN_W'(1);
          hidx    <= '0;
          if (grant) begin
            wp <= wp_nx;
            if (in_last) st <= (MIN_FRAME > 1) ? S_PAD : S_HDR;
            else         st <= S_DATA;
          end else if (!in_last) begin
            st <= S_DROP;
          end
        end
        S_DATA: if (in_valid) begin
          wp  <= wp_nx;
          len <= len_p1;
          if (in_last) st <= (len_p1 < LEN_W'(MIN_FRAME)) ? S_PAD : S_HDR;
        end
        S_PAD: begin
          wp  <= wp_nx;
          len <= len_p1;
          if (len_p1 >= LEN_W'(MIN_FRAME)) st <= S_HDR;
        end
        S_HDR: begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) begin
            st        <= S_IDLE;
            rx_irq    <= 1'b1;
            next_page <= np;
          end
        end
        S_DROP: if (in_valid && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PG_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PG_W-1:0] start_pg,
  input logic [PG_W-1:0] stop_pg,
  input logic            stop_cmd,
  input logic            in_valid,
  input logic            in_ready,
  input logic            mem_we,
  input logic [PG_W+7:0] mem_addr,
  input logic            rx_irq,
  input logic            idle,
  input logic            discard
);
  a_r1_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && in_valid && stop_cmd) |-> !mem_we);

  a_r3_no_write_when_refused: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> !mem_we);

  a_r5_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= {start_pg, 8'h00}) && (mem_addr < {stop_pg, 8'h00}));

  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  a_r10_busy_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> mem_we);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_pg(start_pg), .stop_pg(stop_pg),
  .stop_cmd(stop_cmd), .in_valid(in_valid), .in_ready(in_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .rx_irq(rx_irq),
  .idle(idle), .discard(discard)
);

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] start_pg = 8'h46, stop_pg = 8'h80, bnd_pg = 8'h46, cur_pg = 8'h46;
  logic stop_cmd = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, mem_we, rx_irq;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, next_page;

  int errors = 0, checks = 0, wcount = 0;
  logic [7:0] bmem [int];

  always #4 clk = ~clk;

  rx_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .cur_pg(cur_pg), .stop_cmd(stop_cmd),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .next_page(next_page), .rx_irq(rx_irq)
  );

  always @(posedge clk) if (mem_we) begin
    bmem[int'(mem_addr)] = mem_wdata;
    wcount++;
  end

  // {start, stop, cur, bnd, len[11:0], accept}
  localparam logic [44:0] VEC [8] = '{
    {8'h46, 8'h80, 8'h46, 8'h46, 12'd100,  1'b1},
    {8'h46, 8'h80, 8'h47, 8'h46, 12'd30,   1'b1},
    {8'h46, 8'h80, 8'h48, 8'h46, 12'd1514, 1'b1},
    {8'h46, 8'h80, 8'h7e, 8'h50, 12'd600,  1'b1},
    {8'h46, 8'h80, 8'h50, 8'h55, 12'd200,  1'b0},
    {8'h46, 8'h80, 8'h50, 8'h56, 12'd200,  1'b1},
    {8'h46, 8'h80, 8'h60, 8'h48, 12'd1,    1'b1},
    {8'h46, 8'h80, 8'h7f, 8'h70, 12'd100,  1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(seed + i);
      in_last  = (i == len - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  function automatic int exp_addr(int cur, int st, int sp, int i);
    int a = cur * 256 + 4 + i;
    if (a >= sp * 256) a -= (sp - st) * 256;
    return a;
  endfunction

  task automatic run_frame(input int st, input int sp, input int cur, input int bnd,
                           input int len, input bit acc, input bit stopped, input int seed);
    int w0, stored, np, seen_np, bad_d, bad_h, addr;
    bit seen;
    start_pg = 8'(st); stop_pg = 8'(sp); cur_pg = 8'(cur); bnd_pg = 8'(bnd);
    stop_cmd = stopped;
    w0 = wcount;
    send(len, seed);
    if (len < 60) check(in_ready == 1'b0, "R10 ready low after last", in_ready, 0);
    seen = 1'b0; seen_np = 0;
    for (int c = 0; c < 120 && !seen; c++) begin
      @(negedge clk);
      if (rx_irq) begin seen = 1'b1; seen_np = next_page; end
    end
    stop_cmd = 1'b0;
    if (!acc) begin
      check(!seen, stopped ? "R1 stopped irq" : "R3 refused irq", seen, 0);
      check(wcount == w0, stopped ? "R1 stopped writes" : "R2 refused writes",
            wcount - w0, 0);
      return;
    end
    stored = (len < 60) ? 60 : len;
    np = cur + (stored + 8 + 255) / 256;
    if (np >= sp) np -= (sp - st);
    check(seen, "R9 irq pulse", seen, 1);
    check(seen_np == np, "R8 next page", seen_np, np);
    check(wcount - w0 == stored + 4, "R4 write count", wcount - w0, stored + 4);
    bad_d = 0;
    for (int i = 0; i < stored; i++) begin
      addr = exp_addr(cur, st, sp, i);
      if (!bmem.exists(addr) || bmem[addr] != ((i < len) ? 8'(seed + i) : 8'h00)) bad_d++;
    end
    check(bad_d == 0, (len < 60) ? "R6 padded data" : "R4/R5 data placement", bad_d, 0);
    bad_h = 0;
    if (bmem[cur*256]   != 8'h01)               bad_h++;
    if (bmem[cur*256+1] != 8'(np))              bad_h++;
    if (bmem[cur*256+2] != 8'(stored + 4))      bad_h++;
    if (bmem[cur*256+3] != 8'((stored + 4) >> 8)) bad_h++;
    check(bad_h == 0, "R7 header bytes", bad_h, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && mem_we == 1'b0 && rx_irq == 1'b0, "R11 in reset",
          {in_ready, mem_we, rx_irq}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && mem_we == 1'b0 && rx_irq == 1'b0, "R11 after reset",
          {in_ready, mem_we, rx_irq}, 3'b100);

    for (int k = 0; k < 8; k++) begin
      logic [44:0] v;
      v = VEC[k];
      run_frame(v[44:37], v[36:29], v[28:21], v[20:13], v[12:1], v[0], 1'b0, 16 * k + 3);
    end

    // R1: stop bit refuses a frame despite ample space
    run_frame(8'h46, 8'h80, 8'h46, 8'h46, 80, 1'b0, 1'b1, 8'h55);
    // back to running: same frame accepted
    run_frame(8'h46, 8'h80, 8'h46, 8'h46, 80, 1'b1, 1'b0, 8'h77);
    // R5: wrap with a small ring, frame straddles the stop page
    run_frame(8'h10, 8'h20, 8'h1e, 8'h18, 700, 1'b1, 1'b0, 8'h21);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule